// File: doc/BRIEF.md
# Modulated Phase Accumulator Core

This block is the arithmetic heart of a numerically controlled oscillator. Every clock it adds a 32-bit phase increment to a running phase register, which wraps modulo 2^32. It then offsets the top of that phase separately for a sine channel and a cosine channel, and produces two 13-bit table addresses for lookup tables that sit outside the block. The increment is a carrier word. A pre-scaled frequency-modulation word can be added to it or taken from it, with a flag choosing which.

New values enter through three active-low load strobes: one for the carrier, one for the modulation word and one for the phase offsets. Each load type passes through a fixed-length matched delay. The old increment or offset therefore stays in force until the exact cycle the new one takes over, with no intermediate value. An active-low sync output pulses for one cycle to mark that cycle. A simultaneous-load input lets a single modulation strobe commit the carrier and the modulation word together.

Top module: `pac_core`

## Requirements
- R1: After reset and before any load strobe falls, both addresses read 0 and syncN stays 1.
- R2: Each clock the phase register gains the effective increment, wrapping modulo 2^32. With zero offsets, each address equals phase bits 31..19 as they stood one clock earlier.
- R3: carryIn high adds one at bit 0 of the phase register on each clock where it is sampled high.
- R4: A command edge is the first rising edge at which a load strobe is sampled low after being sampled high. Data is taken on the edge that follows the command edge. A new increment first shows in the addresses on the 19th edge after its command edge.
- R5: The effective increment equals carrier + modulation word when fmSub is 0, and carrier - modulation word when fmSub is 1. fmSub is captured on the same edge as the modulation word.
- R6: When simLoad is 1 at capture, a fall on fmLoadN captures both the carrier and the modulation word. When simLoad is 0, only the modulation word is captured and the previous carrier is kept.
- R7: Each address equals the phase top bits plus its 12-bit offset shifted left by one, modulo 8192, so offset 0x800 is a half turn. A new offset first shows on the 12th edge after its command edge.
- R8: When phSelBuf is 0 at capture, phDirect is applied to both channels. When it is 1, phSine goes to the sine channel and phCos to the cosine channel.
- R9: syncN is low for exactly one cycle, following the 19th edge after a carrier or modulation command edge and the 12th edge after a phase command edge. It is high at all other times.
- R10: Up to the edge where a change takes effect, the addresses keep following the old increment and offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| carrierWord | input | 32 | Carrier increment from the register mux |
| fmWord | input | 32 | Pre-scaled modulation increment |
| fmSub | input | 1 | 1 subtracts the modulation word, 0 adds it |
| simLoad | input | 1 | 1 makes a modulation load also capture the carrier |
| frLoadN | input | 1 | Carrier load strobe, acts on falling edge |
| fmLoadN | input | 1 | Modulation load strobe, acts on falling edge |
| phLoadN | input | 1 | Phase offset load strobe, acts on falling edge |
| phSelBuf | input | 1 | 0 uses phDirect for both channels, 1 uses the separate words |
| phDirect | input | 12 | Shared phase offset |
| phSine | input | 12 | Sine channel phase offset |
| phCos | input | 12 | Cosine channel phase offset |
| carryIn | input | 1 | Carry into bit 0 of the phase register |
| sinAddr | output | 13 | Sine table address |
| cosAddr | output | 13 | Cosine table address |
| syncN | output | 1 | Active-low one-cycle marker of a change taking effect |

## Verification
The single-cycle sync check assumes that no two load commands come close enough for their take-effect cycles to be adjacent. The hold checks assume that each strobe stays low for at least two sampled edges, so that the data is captured. The stimulus drives every strobe and data change just after a falling clock edge. Each strobe is held low for exactly two edges, and each test starts from reset with at most two loads spaced well apart. Carry-in is raised only in its own test.

// File: rtl/pac_pkg.sv
package pac_pkg;
  // Load requests raised by the control toward the datapath,
  // valid in the cycle that follows a command edge.
  typedef struct packed {
    logic capFreq;   // capture carrier word
    logic capFm;     // capture modulation word and subtract flag
    logic capPh;     // capture phase offsets
  } loadStrb_t;
endpackage

// File: rtl/pac_delay.sv
module pac_delay #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData
);
  logic             stValid [DEPTH];
  logic [WIDTH-1:0] stData  [DEPTH];

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            stValid[k] <= 1'b0;
            stData[k]  <= '0;
          end else begin
            stValid[k] <= inValid;
            stData[k]  <= inData;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            stValid[k] <= 1'b0;
            stData[k]  <= '0;
          end else begin
            stValid[k] <= stValid[k-1];
            stData[k]  <= stData[k-1];
          end
        end
      end
    end
  endgenerate

  assign outValid = stValid[DEPTH-1];
  assign outData  = stData[DEPTH-1];
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frLoadN,
  input  logic               fmLoadN,
  input  logic               phLoadN,
  input  logic               simLoad,
  output pac_pkg::loadStrb_t strb
);
  localparam int NSTRB = 3;

  logic [NSTRB-1:0] rawStrb;
  logic [NSTRB-1:0] fallSeen;

  assign rawStrb = {phLoadN, fmLoadN, frLoadN};

  genvar i;
  generate
    for (i = 0; i < NSTRB; i++) begin : g_edge
      logic sampQ;
      logic sampQQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sampQ  <= 1'b0;
          sampQQ <= 1'b0;
        end else begin
          sampQ  <= rawStrb[i];
          sampQQ <= sampQ;
        end
      end
      assign fallSeen[i] = sampQQ & ~sampQ;
    end
  endgenerate

  always_comb begin
    strb.capFreq = fallSeen[0] | (fallSeen[1] & simLoad);
    strb.capFm   = fallSeen[1];
    strb.capPh   = fallSeen[2];
  end
endmodule

// File: rtl/pac_datapath.sv
module pac_datapath #(
  parameter int ACC_W    = 32,
  parameter int PH_W     = 12,
  parameter int FREQ_LAT = 19,
  parameter int PH_LAT   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  pac_pkg::loadStrb_t strb,
  input  logic [ACC_W-1:0]   carrierWord,
  input  logic [ACC_W-1:0]   fmWord,
  input  logic               fmSub,
  input  logic               phSelBuf,
  input  logic [PH_W-1:0]    phDirect,
  input  logic [PH_W-1:0]    phSine,
  input  logic [PH_W-1:0]    phCos,
  input  logic               carryIn,
  output logic [PH_W:0]      sinAddr,
  output logic [PH_W:0]      cosAddr,
  output logic               syncN
);
  localparam int ADDR_W      = PH_W + 1;
  localparam int FREQ_STAGES = FREQ_LAT - 4;
  localparam int PH_STAGES   = PH_LAT - 3;
  localparam int PHP_W       = 2 * PH_W;

  logic [ACC_W-1:0] carrierHold;
  logic [ACC_W-1:0] fmHold;
  logic             fmSubHold;
  logic [PH_W-1:0]  sinHold;
  logic [PH_W-1:0]  cosHold;
  logic             freqPend;
  logic             phPend;

  logic [ACC_W-1:0] incNew;
  logic             freqOutValid;
  logic [ACC_W-1:0] freqOutData;
  logic             phOutValid;
  logic [PHP_W-1:0] phOutData;

  logic [ACC_W-1:0] incEff;
  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  sinOffEff;
  logic [PH_W-1:0]  cosOffEff;
  logic             freqFire1;
  logic             freqFire2;
  logic             phFire1;

  // capture stage: one edge after the command edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrierHold <= '0;
      fmHold      <= '0;
      fmSubHold   <= 1'b0;
      sinHold     <= '0;
      cosHold     <= '0;
      freqPend    <= 1'b0;
      phPend      <= 1'b0;
    end else begin
      freqPend <= strb.capFreq | strb.capFm;
      phPend   <= strb.capPh;
      if (strb.capFreq) carrierHold <= carrierWord;
      if (strb.capFm) begin
        fmHold    <= fmWord;
        fmSubHold <= fmSub;
      end
      if (strb.capPh) begin
        if (phSelBuf) begin
          sinHold <= phSine;
          cosHold <= phCos;
        end else begin
          sinHold <= phDirect;
          cosHold <= phDirect;
        end
      end
    end
  end

  always_comb begin
    if (fmSubHold) incNew = carrierHold - fmHold;
    else           incNew = carrierHold + fmHold;
  end

  pac_delay #(.WIDTH(ACC_W), .DEPTH(FREQ_STAGES)) u_freqDly (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (freqPend),
    .inData   (incNew),
    .outValid (freqOutValid),
    .outData  (freqOutData)
  );

  pac_delay #(.WIDTH(PHP_W), .DEPTH(PH_STAGES)) u_phDly (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (phPend),
    .inData   ({sinHold, cosHold}),
    .outValid (phOutValid),
    .outData  (phOutData)
  );

  // effective values, accumulator and outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incEff    <= '0;
      acc       <= '0;
      sinOffEff <= '0;
      cosOffEff <= '0;
      sinAddr   <= '0;
      cosAddr   <= '0;
      freqFire1 <= 1'b0;
      freqFire2 <= 1'b0;
      phFire1   <= 1'b0;
      syncN     <= 1'b1;
    end else begin
      if (freqOutValid) incEff <= freqOutData;
      if (phOutValid) begin
        sinOffEff <= phOutData[PHP_W-1:PH_W];
        cosOffEff <= phOutData[PH_W-1:0];
      end
      acc       <= acc + incEff + ACC_W'(carryIn);
      sinAddr   <= acc[ACC_W-1 -: ADDR_W] + {sinOffEff, 1'b0};
      cosAddr   <= acc[ACC_W-1 -: ADDR_W] + {cosOffEff, 1'b0};
      freqFire1 <= freqOutValid;
      freqFire2 <= freqFire1;
      phFire1   <= phOutValid;
      syncN     <= ~(freqFire2 | phFire1);
    end
  end
endmodule

// File: rtl/pac_core.sv
module pac_core #(
  parameter int ACC_W    = 32,
  parameter int PH_W     = 12,
  parameter int FREQ_LAT = 19,
  parameter int PH_LAT   = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ACC_W-1:0] carrierWord,
  input  logic [ACC_W-1:0] fmWord,
  input  logic            fmSub,
  input  logic            simLoad,
  input  logic            frLoadN,
  input  logic            fmLoadN,
  input  logic            phLoadN,
  input  logic            phSelBuf,
  input  logic [PH_W-1:0] phDirect,
  input  logic [PH_W-1:0] phSine,
  input  logic [PH_W-1:0] phCos,
  input  logic            carryIn,
  output logic [PH_W:0]   sinAddr,
  output logic [PH_W:0]   cosAddr,
  output logic            syncN
);
  pac_pkg::loadStrb_t strb;

  pac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frLoadN (frLoadN),
    .fmLoadN (fmLoadN),
    .phLoadN (phLoadN),
    .simLoad (simLoad),
    .strb    (strb)
  );

  pac_datapath #(
    .ACC_W(ACC_W), .PH_W(PH_W), .FREQ_LAT(FREQ_LAT), .PH_LAT(PH_LAT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .carrierWord (carrierWord),
    .fmWord      (fmWord),
    .fmSub       (fmSub),
    .phSelBuf    (phSelBuf),
    .phDirect    (phDirect),
    .phSine      (phSine),
    .phCos       (phCos),
    .carryIn     (carryIn),
    .sinAddr     (sinAddr),
    .cosAddr     (cosAddr),
    .syncN       (syncN)
  );
endmodule

// File: rtl/pac_chk.sv
module pac_chk #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               syncN,
  input pac_pkg::loadStrb_t strb,
  input logic [ACC_W-1:0]   carrierWord,
  input logic [ACC_W-1:0]   carrierHold,
  input logic [ACC_W-1:0]   incEff,
  input logic               freqOutValid,
  input logic               phOutValid,
  input logic [PH_W-1:0]    sinOffEff,
  input logic [PH_W-1:0]    cosOffEff,
  input logic               phSelBuf,
  input logic [PH_W-1:0]    sinHold,
  input logic [PH_W-1:0]    cosHold
);
  // R9
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncN |=> syncN);

  // R10
  inc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !freqOutValid |=> $stable(incEff));

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !phOutValid |=> ($stable(sinOffEff) && $stable(cosOffEff)));

  // R4
  carrier_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capFreq |=> (carrierHold == $past(carrierWord)));

  // R8
  direct_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capPh && !phSelBuf) |=> (sinHold == cosHold));
endmodule

bind pac_core pac_chk #(.ACC_W(ACC_W), .PH_W(PH_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .syncN        (syncN),
  .strb         (strb),
  .carrierWord  (carrierWord),
  .carrierHold  (u_dp.carrierHold),
  .incEff       (u_dp.incEff),
  .freqOutValid (u_dp.freqOutValid),
  .phOutValid   (u_dp.phOutValid),
  .sinOffEff    (u_dp.sinOffEff),
  .cosOffEff    (u_dp.cosOffEff),
  .phSelBuf     (phSelBuf),
  .sinHold      (u_dp.sinHold),
  .cosHold      (u_dp.cosHold)
);

// File: tb/sim_pac_core.sv
`timescale 1ns/1ps
module sim_pac_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] carrierWord = '0;
  logic [31:0] fmWord = '0;
  logic        fmSub = 1'b0;
  logic        simLoad = 1'b0;
  logic        frLoadN = 1'b1;
  logic        fmLoadN = 1'b1;
  logic        phLoadN = 1'b1;
  logic        phSelBuf = 1'b0;
  logic [11:0] phDirect = '0;
  logic [11:0] phSine = '0;
  logic [11:0] phCos = '0;
  logic        carryIn = 1'b0;
  logic [12:0] sinAddr;
  logic [12:0] cosAddr;
  logic        syncN;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  pac_core u0 (
    .clk(clk), .rstN(rstN), .carrierWord(carrierWord), .fmWord(fmWord),
    .fmSub(fmSub), .simLoad(simLoad), .frLoadN(frLoadN), .fmLoadN(fmLoadN),
    .phLoadN(phLoadN), .phSelBuf(phSelBuf), .phDirect(phDirect),
    .phSine(phSine), .phCos(phCos), .carryIn(carryIn),
    .sinAddr(sinAddr), .cosAddr(cosAddr), .syncN(syncN)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic at(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    frLoadN = 1'b1; fmLoadN = 1'b1; phLoadN = 1'b1;
    carrierWord = '0; fmWord = '0; fmSub = 1'b0; simLoad = 1'b0;
    phSelBuf = 1'b0; phDirect = '0; phSine = '0; phCos = '0; carryIn = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // which: 0 carrier, 1 modulation, 2 phase; returns the command edge
  task automatic pulse(input int which, output int cmdEdge);
    @(negedge clk);
    cmdEdge = cyc + 1;
    case (which)
      0: frLoadN = 1'b0;
      1: fmLoadN = 1'b0;
      default: phLoadN = 1'b0;
    endcase
    at(cmdEdge + 1);
    frLoadN = 1'b1; fmLoadN = 1'b1; phLoadN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    repeat (10) @(negedge clk);
    check("R1 sin idle", sinAddr, 0);
    check("R1 cos idle", cosAddr, 0);
    check("R1 sync idle", syncN, 1);
  endtask

  task automatic testFreq();
    int e;
    doReset();
    carrierWord = 32'h0100_0000;
    pulse(0, e);
    at(e + 18);
    check("R10 old increment kept", sinAddr, 0);
    check("R9 sync high before", syncN, 1);
    at(e + 19);
    check("R4 new sin at 19", sinAddr, 32);
    check("R4 new cos at 19", cosAddr, 32);
    check("R9 sync low at 19", syncN, 0);
    at(e + 20);
    check("R2 second step", sinAddr, 64);
    check("R9 sync one cycle", syncN, 1);
  endtask

  task automatic testWrap();
    int e;
    doReset();
    carrierWord = 32'hC000_0000;
    pulse(0, e);
    at(e + 19); check("R2 wrap k1", sinAddr, 6144);
    at(e + 20); check("R2 wrap k2", sinAddr, 4096);
    at(e + 21); check("R2 wrap k3", sinAddr, 2048);
    at(e + 22); check("R2 wrap k4", sinAddr, 0);
  endtask

  task automatic testFm(input logic sub, input int step);
    int e;
    doReset();
    simLoad = 1'b1;
    carrierWord = 32'h0100_0000;
    fmWord = 32'h0080_0000;
    fmSub = sub;
    pulse(1, e);
    at(e + 18);
    check("R6 sim load not yet", sinAddr, 0);
    at(e + 19);
    check("R5 fm first", sinAddr, step);
    check("R9 sync after fm load", syncN, 0);
    at(e + 20);
    check("R5 fm second", sinAddr, 2 * step);
  endtask

  task automatic testFmOnly();
    int e1, e2;
    logic [12:0] s1, s2;
    doReset();
    carrierWord = 32'h0100_0000;
    pulse(0, e1);
    at(e1 + 25);
    simLoad = 1'b0;
    carrierWord = 32'h0400_0000;
    fmWord = 32'h0080_0000;
    fmSub = 1'b0;
    pulse(1, e2);
    at(e2 + 19);
    s1 = sinAddr;
    check("R9 sync after fm only", syncN, 0);
    at(e2 + 20);
    s2 = sinAddr;
    check("R6 carrier kept step", 32'(13'(s2 - s1)), 48);
  endtask

  task automatic testCarry();
    int e;
    doReset();
    carrierWord = 32'h0007_FFFF;
    @(negedge clk);
    carryIn = 1'b1;
    frLoadN = 1'b0;
    e = cyc + 1;
    at(e + 1);
    frLoadN = 1'b1;
    at(e + 19); check("R3 carry first", sinAddr, 1);
    at(e + 20); check("R3 carry second", sinAddr, 2);
    carryIn = 1'b0;
  endtask

  task automatic testPhDirect();
    int e;
    doReset();
    phSelBuf = 1'b0;
    phDirect = 12'h800; phSine = 12'h111; phCos = 12'h222;
    pulse(2, e);
    at(e + 11);
    check("R10 old offset kept", sinAddr, 0);
    check("R9 sync high before phase", syncN, 1);
    at(e + 12);
    check("R8 direct sin", sinAddr, 4096);
    check("R8 direct cos", cosAddr, 4096);
    check("R9 sync low at 12", syncN, 0);
    at(e + 13);
    check("R9 phase pulse one cycle", syncN, 1);
  endtask

  task automatic testPhBuf();
    int e;
    doReset();
    phSelBuf = 1'b1;
    phDirect = 12'h7FF; phSine = 12'h400; phCos = 12'h123;
    pulse(2, e);
    at(e + 12);
    check("R8 buffered sin", sinAddr, 13'h800);
    check("R8 buffered cos", cosAddr, 13'h246);
  endtask

  task automatic testPhRunning();
    int e1, e2;
    doReset();
    carrierWord = 32'h0100_0000;
    pulse(0, e1);
    at(e1 + 28);
    phSelBuf = 1'b0;
    phDirect = 12'hF00;
    pulse(2, e2);
    at(e2 + 11);
    check("R7 before offset", sinAddr, 32'(13'(32 * (e2 + 11 - e1 - 18))));
    at(e2 + 12);
    check("R7 offset wraps", sinAddr, 32'(13'(32 * (e2 + 12 - e1 - 18) + 7680)));
    at(e2 + 13);
    check("R7 offset next", cosAddr, 32'(13'(32 * (e2 + 13 - e1 - 18) + 7680)));
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testFreq();
    testWrap();
    testFm(1'b0, 48);
    testFm(1'b1, 16);
    testFmOnly();
    testCarry();
    testPhDirect();
    testPhBuf();
    testPhRunning();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule